// File: doc/BRIEF.md
# Bidirectional Position Tracking Shift Register

This block keeps a bit-per-position image of a moving line, such as a conveyor carrying parts past an inspection station. Each advance of the line arrives as a trigger event. On every accepted rising edge of that trigger, the register moves its contents one place and takes a fresh serial data bit, for example a defect flag, in at the entry end. The bit pushed out of the far end is held in an unload flag until the next shift. Each register bit therefore stays aligned with one physical position on the line.

The active length can be set at run time from 1 to the parameterised maximum. A direction input chooses the shift direction. In upward mode, data moves toward higher positions and enters at position 0. In downward mode, data moves toward lower positions and enters at the top active position. A tap index selects one position whose bit drives an action output, such as a reject ejector. The raw trigger is synchronised and debounced inside the block, so a bouncing contact or a trigger held high yields exactly one shift.

Top module: `trk_shift_reg`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `track_q`, `unload_q` and `tap_q` are all 0.
- R2: With `dir_down` = 0 (upward), a shift moves every bit from position i to position i+1. `data_in` enters position 0, and the bit that was at position LEN-1 goes to `unload_q`.
- R3: With `dir_down` = 1 (downward), a shift moves every bit from position i to position i-1. `data_in` enters position LEN-1, and the bit that was at position 0 goes to `unload_q`.
- R4: Exactly one shift follows each accepted rising edge of the trigger, however long the trigger stays high. A falling edge causes no shift. Between shifts, `track_q` and `unload_q` hold their values.
- R5: A trigger level change is accepted only after the synchronised level has differed from the accepted level for `db_cycles` consecutive clocks (`db_cycles` = 0 counts as 1). A shorter glitch causes no shift.
- R6: The effective length LEN is `len_cfg`, clamped to the range 1..MAX_POS (0 reads as 1). `track_q` bits at positions LEN and above always read 0.
- R7: `tap_q` equals the bit of `track_q` at index `tap_sel`, one clock after `tap_sel` was applied. It is 0 when `tap_sel` is LEN or above.
- R8: `clr` is a synchronous clear that zeroes `track_q` and `unload_q`. It takes priority over a shift in the same cycle.
- R9: In upward mode with LEN = 8 and `tap_sel` = 6, a 1 loaded on pulse 1 drives `tap_q` high after pulse 7 only, and low again after pulse 8.
- R10: In downward mode with LEN = 16, the newest sample sits at bit 15. A 1 loaded on one shift reaches bit 0 after 15 further shifts, and leaves into `unload_q` on the 16th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the register and the unload flag |
| trig_in | input | 1 | Raw line-advance trigger (asynchronous, may bounce) |
| db_cycles | input | DB_W | Clocks a trigger level must persist before it is accepted |
| dir_down | input | 1 | 0: shift toward higher positions; 1: toward lower positions |
| data_in | input | 1 | Serial bit taken in at the entry end on a shift |
| len_cfg | input | $clog2(MAX_POS+1) | Active length, clamped to 1..MAX_POS |
| tap_sel | input | $clog2(MAX_POS) | Position driving `tap_q` |
| track_q | output | MAX_POS | Tracking register contents, bit i = position i |
| unload_q | output | 1 | Bit pushed out of the far end by the last shift |
| tap_q | output | 1 | Registered bit at the tapped position |

## Verification
Several properties are checked on every cycle: the entry bit and the unloaded bit for each direction, one shift per trigger pulse, hold between shifts, zeros above the active length, clear priority and the tap relation. These checks compare each output against what it was one cycle earlier. Whole-line scenarios can only be shown by the bench's scenarios. These include the defect walking from the inspection point to the ejector tap, a sample ageing out of a 16-position history, glitches shorter than the debounce window being rejected, a trigger held high for many cycles, and the length clamp.

// File: rtl/trk_pkg.sv
package trk_pkg;
  // Shift direction: which way the contents travel on a line advance.
  typedef enum logic {
    SHIFT_UP   = 1'b0,
    SHIFT_DOWN = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/trk_debounce.sv
module trk_debounce #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            raw_in,
  input  logic [DB_W-1:0] db_cycles,
  output logic            level_q
);
  localparam int CW = DB_W + 1;

  logic            meta_q, sync_q;
  logic [DB_W-1:0] run_q;
  logic [CW-1:0]   run_inc;
  logic [CW-1:0]   thresh;

  // two-flop synchroniser for the asynchronous trigger
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
    end
  end

  assign run_inc = {1'b0, run_q} + CW'(1);
  assign thresh  = (db_cycles == '0) ? CW'(1) : {1'b0, db_cycles};

  // accept a new level only after it has persisted for thresh clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (sync_q == level_q) begin
      run_q <= '0;
    end else if (run_inc >= thresh) begin
      level_q <= sync_q;
      run_q   <= '0;
    end else begin
      run_q <= run_inc[DB_W-1:0];
    end
  end
endmodule

// File: rtl/trk_edge.sv
module trk_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/trk_shift_core.sv
module trk_shift_core
  import trk_pkg::*;
#(
  parameter int MAX_POS = 16,
  parameter int LW      = $clog2(MAX_POS + 1),
  parameter int TW      = $clog2(MAX_POS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               shift_en,
  input  shift_dir_e         dir,
  input  logic               data_in,
  input  logic [LW-1:0]      len_cfg,
  input  logic [TW-1:0]      tap_sel,
  output logic [MAX_POS-1:0] track_q,
  output logic               unload_q,
  output logic               tap_q
);
  localparam int              TP      = 1 << TW;
  localparam logic [LW-1:0]   LEN_MAX = LW'(MAX_POS);

  logic [LW-1:0]      len_eff, len_m1;
  logic [MAX_POS-1:0] at_top, act_mask, up_nxt, dn_nxt, nxt;
  logic [TP-1:0]      nxt_pad;
  logic               out_bit;

  always_comb begin
    if (len_cfg == '0)          len_eff = LW'(1);
    else if (len_cfg > LEN_MAX) len_eff = LEN_MAX;
    else                        len_eff = len_cfg;
  end
  assign len_m1 = len_eff - LW'(1);

  // per-position next-state for each direction
  for (genvar i = 0; i < MAX_POS; i++) begin : g_pos
    localparam logic [LW-1:0] IDX = LW'(i);
    assign at_top[i]   = (len_m1 == IDX);
    assign act_mask[i] = (IDX < len_eff);
    if (i == 0) begin : g_lo
      assign up_nxt[i] = data_in;
    end else begin : g_mid
      assign up_nxt[i] = track_q[i-1];
    end
    if (i == MAX_POS - 1) begin : g_hi
      assign dn_nxt[i] = at_top[i] ? data_in : 1'b0;
    end else begin : g_rest
      assign dn_nxt[i] = at_top[i] ? data_in : track_q[i+1];
    end
  end

  assign out_bit = (dir == SHIFT_DOWN) ? track_q[0] : |(track_q & at_top);

  always_comb begin
    if (!shift_en)              nxt = track_q & act_mask;
    else if (dir == SHIFT_DOWN) nxt = dn_nxt & act_mask;
    else                        nxt = up_nxt & act_mask;
  end

  assign nxt_pad = TP'(nxt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      track_q  <= '0;
      unload_q <= 1'b0;
      tap_q    <= 1'b0;
    end else begin
      track_q <= nxt;
      tap_q   <= nxt_pad[tap_sel];
      if (shift_en) unload_q <= out_bit;
    end
  end
endmodule

// File: rtl/trk_shift_reg.sv
module trk_shift_reg
  import trk_pkg::*;
#(
  parameter int MAX_POS = 16,
  parameter int DB_W    = 8,
  localparam int LW     = $clog2(MAX_POS + 1),
  localparam int TW     = $clog2(MAX_POS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               trig_in,
  input  logic [DB_W-1:0]    db_cycles,
  input  logic               dir_down,
  input  logic               data_in,
  input  logic [LW-1:0]      len_cfg,
  input  logic [TW-1:0]      tap_sel,
  output logic [MAX_POS-1:0] track_q,
  output logic               unload_q,
  output logic               tap_q
);
  logic       trig_lvl;
  logic       shift_ev;
  shift_dir_e dir;

  assign dir = shift_dir_e'(dir_down);

  trk_debounce #(.DB_W(DB_W)) u_db (
    .clk(clk), .rst(rst), .raw_in(trig_in),
    .db_cycles(db_cycles), .level_q(trig_lvl)
  );

  trk_edge u_edge (
    .clk(clk), .rst(rst), .level(trig_lvl), .rise(shift_ev)
  );

  trk_shift_core #(.MAX_POS(MAX_POS), .LW(LW), .TW(TW)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .shift_en(shift_ev), .dir(dir),
    .data_in(data_in), .len_cfg(len_cfg), .tap_sel(tap_sel),
    .track_q(track_q), .unload_q(unload_q), .tap_q(tap_q)
  );
endmodule

// File: rtl/trk_shift_reg_chk.sv
module trk_shift_reg_chk #(
  parameter int MAX_POS = 16,
  parameter int LW      = $clog2(MAX_POS + 1),
  parameter int TW      = $clog2(MAX_POS)
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               dir_down,
  input logic               data_in,
  input logic [LW-1:0]      len_cfg,
  input logic [TW-1:0]      tap_sel,
  input logic [MAX_POS-1:0] track_q,
  input logic               unload_q,
  input logic               tap_q,
  input logic               shift_ev
);
  localparam int TP = 1 << TW;

  logic [LW-1:0] lenc, lenc_d;
  logic [TW-1:0] top_i, top_i_d, tap_d;
  logic          din_d, top_bit_d, bit0_d;
  logic [TP-1:0] trk_pad;

  assign lenc  = (len_cfg == '0) ? LW'(1) :
                 (len_cfg > LW'(MAX_POS)) ? LW'(MAX_POS) : len_cfg;
  assign top_i = TW'(lenc - LW'(1));
  assign trk_pad = TP'(track_q);

  always_ff @(posedge clk) begin
    lenc_d    <= lenc;
    top_i_d   <= top_i;
    tap_d     <= tap_sel;
    din_d     <= data_in;
    top_bit_d <= track_q[top_i];
    bit0_d    <= track_q[0];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (track_q == '0 && !unload_q && !tap_q));

  // R2
  up_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_ev && !clr && !dir_down) |=> (track_q[0] == din_d && unload_q == top_bit_d));

  // R3
  down_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_ev && !clr && dir_down) |=> (track_q[top_i_d] == din_d && unload_q == bit0_d));

  // R4
  one_shift_per_edge_chk: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> !shift_ev);

  // R4
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_ev && !clr && $stable(len_cfg)) |=> ($stable(track_q) && $stable(unload_q)));

  // R6
  above_len_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((track_q >> lenc_d) == '0));

  // R7
  tap_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tap_q == trk_pad[tap_d]));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (track_q == '0 && !unload_q));
endmodule

bind trk_shift_reg trk_shift_reg_chk #(.MAX_POS(MAX_POS)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .dir_down(dir_down), .data_in(data_in),
  .len_cfg(len_cfg), .tap_sel(tap_sel), .track_q(track_q),
  .unload_q(unload_q), .tap_q(tap_q), .shift_ev(shift_ev)
);

// File: tb/tb_trk_shift_reg.sv
module tb_trk_shift_reg;
  localparam int MAX_POS = 16;
  localparam int DB_W    = 8;
  localparam int LW      = $clog2(MAX_POS + 1);
  localparam int TW      = $clog2(MAX_POS);

  logic               clk = 1'b0;
  logic               rst, clr, trig_in, dir_down, data_in;
  logic [DB_W-1:0]    db_cycles;
  logic [LW-1:0]      len_cfg;
  logic [TW-1:0]      tap_sel;
  logic [MAX_POS-1:0] track_q;
  logic               unload_q, tap_q;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  trk_shift_reg #(.MAX_POS(MAX_POS), .DB_W(DB_W)) dut (
    .clk(clk), .rst(rst), .clr(clr), .trig_in(trig_in), .db_cycles(db_cycles),
    .dir_down(dir_down), .data_in(data_in), .len_cfg(len_cfg), .tap_sel(tap_sel),
    .track_q(track_q), .unload_q(unload_q), .tap_q(tap_q)
  );

  // {data_in, expected track, expected unload, expected tap}: upward, LEN 8, tap 6
  localparam logic [18:0] UP_VEC [0:8] = '{
    {1'b1, 16'h0001, 1'b0, 1'b0},
    {1'b0, 16'h0002, 1'b0, 1'b0},
    {1'b0, 16'h0004, 1'b0, 1'b0},
    {1'b0, 16'h0008, 1'b0, 1'b0},
    {1'b0, 16'h0010, 1'b0, 1'b0},
    {1'b0, 16'h0020, 1'b0, 1'b0},
    {1'b0, 16'h0040, 1'b0, 1'b1},
    {1'b0, 16'h0080, 1'b0, 1'b0},
    {1'b1, 16'h0001, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    data_in = d;
    trig_in = 1'b1;
    wait_clk(16);
    trig_in = 1'b0;
    wait_clk(16);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    wait_clk(1);
    clr = 1'b0;
    wait_clk(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; trig_in = 1'b0; dir_down = 1'b0; data_in = 1'b0;
    db_cycles = 8'd4; len_cfg = LW'(8); tap_sel = TW'(6);
    wait_clk(5);
    chk("R1 track in reset", 32'(track_q), 0);
    rst = 1'b0;
    wait_clk(1);
    chk("R1 track after reset", 32'(track_q), 0);
    chk("R1 unload after reset", 32'(unload_q), 0);
    chk("R1 tap after reset", 32'(tap_q), 0);

    // R2 R7 R9: defect walk toward the ejector tap
    for (int v = 0; v < 9; v++) begin
      pulse(UP_VEC[v][18]);
      chk($sformatf("R2 track pulse %0d", v + 1), 32'(track_q), 32'(UP_VEC[v][17:2]));
      chk($sformatf("R2 unload pulse %0d", v + 1), 32'(unload_q), 32'(UP_VEC[v][1]));
      chk($sformatf("R9 tap pulse %0d", v + 1), 32'(tap_q), 32'(UP_VEC[v][0]));
    end

    // R8: plain clear zeroes register and unload flag
    do_clear();
    chk("R8 track after clear", 32'(track_q), 0);
    chk("R8 unload after clear", 32'(unload_q), 0);

    // R10 R3: downward, 16 positions, sample ageing out
    dir_down = 1'b1; len_cfg = LW'(16);
    pulse(1'b1);
    chk("R10 newest at bit 15", 32'(track_q), 32'h8000);
    for (int s = 0; s < 15; s++) pulse(1'b0);
    chk("R10 oldest at bit 0", 32'(track_q), 32'h0001);
    chk("R10 not yet unloaded", 32'(unload_q), 0);
    pulse(1'b0);
    chk("R10 dropped out", 32'(track_q), 0);
    chk("R3 unload from bit 0", 32'(unload_q), 1);

    // R3 R6: downward entry at LEN-1 with LEN 5
    do_clear();
    len_cfg = LW'(5);
    pulse(1'b1);
    chk("R3 entry at LEN-1", 32'(track_q), 32'h0010);
    pulse(1'b1);
    chk("R3 second entry", 32'(track_q), 32'h0018);

    // R4: trigger held high shifts once; falling edge does nothing
    do_clear();
    dir_down = 1'b0; len_cfg = LW'(8);
    data_in = 1'b1; trig_in = 1'b1;
    wait_clk(100);
    chk("R4 one shift while held", 32'(track_q), 32'h0001);
    data_in = 1'b0; trig_in = 1'b0;
    wait_clk(20);
    chk("R4 no shift on fall", 32'(track_q), 32'h0001);

    // R5: glitches shorter than the filter window are ignored
    db_cycles = 8'd8;
    data_in = 1'b1;
    trig_in = 1'b1; wait_clk(3); trig_in = 1'b0; wait_clk(20);
    chk("R5 3-cycle glitch", 32'(track_q), 32'h0001);
    trig_in = 1'b1; wait_clk(6); trig_in = 1'b0; wait_clk(20);
    chk("R5 6-cycle glitch", 32'(track_q), 32'h0001);
    pulse(1'b1);
    chk("R5 stable pulse accepted", 32'(track_q), 32'h0003);
    db_cycles = 8'd4;

    // R6: length 0 behaves as 1
    do_clear();
    len_cfg = '0;
    pulse(1'b1);
    chk("R6 len0 track", 32'(track_q), 32'h0001);
    pulse(1'b0);
    chk("R6 len0 track after", 32'(track_q), 0);
    chk("R6 len0 unload", 32'(unload_q), 1);

    // R6 R7: tap beyond length reads 0, upper bits stay 0
    do_clear();
    len_cfg = LW'(4); tap_sel = TW'(9);
    for (int s = 0; s < 5; s++) pulse(1'b1);
    chk("R6 clipped to length", 32'(track_q), 32'h000F);
    chk("R7 tap beyond length", 32'(tap_q), 0);
    tap_sel = TW'(2);
    wait_clk(2);
    chk("R7 tap inside length", 32'(tap_q), 1);

    // R8: clear held across a pulse wins over the shift
    clr = 1'b1;
    pulse(1'b1);
    clr = 1'b0;
    wait_clk(2);
    chk("R8 clear beats shift", 32'(track_q), 0);
    chk("R8 unload cleared", 32'(unload_q), 0);

    finish_run();
  end
endmodule